// File: doc/BRIEF.md
# Power-Good Flag Sequencer

The block raises four power-good flags, called A, B, C and D, in a fixed order once a hot-swap start-up has finished. A one-cycle start pulse makes flag A active. Each of the three later flags then becomes active after its own delay, measured from the flag before it. Every delay is exactly 255 ticks of a per-stage tick generator. That generator divides the clock by a programmable amount, so each delay scales linearly with its divider value.

A fault input returns all flags to their inactive level on the next clock edge. Start-up timeout, breaker trip or supply limit violations are all merged onto that one fault pin. A strap input picks the electrical sense of the flags. After the last flag is active, the block raises a request to enter a low-power state.

No data streams through this block. Every pin is a plain level or pulse control signal, and none has a valid/ready handshake or back-pressure.

Top module: `pgood_sequencer`

## Requirements
- R1: While reset is held and after it is released with no start, all four flags sit at the inactive level and the sleep request is low.
- R2: A start pulse sampled high with the fault low, while no flag is active, makes flag A active at that clock edge. A start pulse while any flag is active is ignored.
- R3: Flag B becomes active exactly 255*(dB+1) clock cycles after flag A. C follows B after 255*(dC+1) cycles, and D follows C after 255*(dD+1) cycles. The divider field rate_div[DIV_W-1:0] sets dB, the next field sets dC and the top field sets dD.
- R4: The divider values are captured at the edge that accepts a start. Changes to rate_div after that edge do not change the running sequence.
- R5: A fault sampled high clears every flag and the sleep request at that edge and discards any partly counted delay. A fault has priority over a start in the same cycle.
- R6: After a fault, a new start begins again from flag A, and the next delay is counted in full.
- R7: The sleep request rises one clock cycle after flag D becomes active. It then stays high until a fault or a reset.
- R8: With pol_hi high, an active flag drives 1 and an inactive flag drives 0. With pol_hi low, both levels are inverted. The strap acts combinationally and can change at any time.
- R9: Flags only ever become active in order. A later flag is never active while an earlier flag is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-up complete pulse |
| fault_i | input | 1 | Merged fault; clears the sequence |
| pol_hi_i | input | 1 | Strap: 1 = active-high flags, 0 = active-low flags |
| rate_div_i | input | 3*DIV_W | Per-stage tick dividers, B in the lowest field |
| flag_o | output | 4 | Flags; bit 0 is A and bit 3 is D, driven at the strap's levels |
| sleep_req_o | output | 1 | Low-power request after flag D |

## Verification
The assertions assume that start and fault are synchronous to the clock. They also assume that a reset is applied before the first start, so the checks on counter bounds and flag order start from a cleared state. The stimulus changes every input only at the falling clock edge. It holds the divider values small so that every delay can be timed exactly, and it places the overlapping start and fault pulses inside counting windows whose cycle positions are known.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  // Stage activity, used by the delay stages for readability.
  typedef enum logic {
    STG_IDLE  = 1'b0,
    STG_COUNT = 1'b1
  } stage_mode_e;

  // Number of tick periods per inter-flag delay.
  localparam int unsigned DEF_PERIODS = 255;

  function automatic int unsigned cnt_width(input int unsigned periods);
    return (periods < 2) ? 1 : $clog2(periods);
  endfunction
endpackage

// File: rtl/pgs_rate_latch.sv
module pgs_rate_latch #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned NUM_DLY = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [NUM_DLY*DIV_W-1:0] div_i,
  output logic [NUM_DLY*DIV_W-1:0] div_o
);
  logic [NUM_DLY*DIV_W-1:0] div_q;

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q[g*DIV_W +: DIV_W] <= '0;
      end else if (load_i) begin
        div_q[g*DIV_W +: DIV_W] <= div_i[g*DIV_W +: DIV_W];
      end
    end
  end

  assign div_o = div_q;

  // R4
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(div_q));
endmodule

// File: rtl/pgs_delay_stage.sv
module pgs_delay_stage
  import pgs_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned PERIODS = DEF_PERIODS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             done_o
);
  localparam int unsigned CNT_W = cnt_width(PERIODS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIODS - 1);

  stage_mode_e      mode;
  logic [DIV_W-1:0] presc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign mode   = run_i ? STG_COUNT : STG_IDLE;
  assign tick   = (mode == STG_COUNT) && (presc_q == div_i);
  assign done_o = tick && (cnt_q == LAST);

  // Tick prescaler: one tick every div_i+1 cycles while counting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (mode == STG_IDLE) begin
      presc_q <= '0;
    end else if (tick) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  // Period counter: wraps after the final period of the delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (mode == STG_IDLE) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && presc_q == '0));
endmodule

// File: rtl/pgs_pol_out.sv
module pgs_pol_out #(
  parameter int unsigned NUM_FLAGS = 4
) (
  input  logic [NUM_FLAGS-1:0] active_i,
  input  logic                 pol_hi_i,
  output logic [NUM_FLAGS-1:0] flag_o
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_pin
    assign flag_o[g] = pol_hi_i ? active_i[g] : ~active_i[g];
  end
endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer
  import pgs_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 4,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned PERIODS   = DEF_PERIODS
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic                               fault_i,
  input  logic                               pol_hi_i,
  input  logic [(NUM_FLAGS-1)*DIV_W-1:0]     rate_div_i,
  output logic [NUM_FLAGS-1:0]               flag_o,
  output logic                               sleep_req_o
);
  localparam int unsigned NUM_DLY = NUM_FLAGS - 1;
  localparam int unsigned LASTF   = NUM_FLAGS - 1;

  logic [NUM_FLAGS-1:0]     act_q;
  logic                     sleep_q;
  logic                     busy;
  logic                     start_ok;
  logic [NUM_DLY-1:0]       run;
  logic [NUM_DLY-1:0]       done;
  logic [NUM_DLY*DIV_W-1:0] div_held;

  assign busy     = |act_q;
  assign start_ok = start_i && !fault_i && !busy;

  pgs_rate_latch #(.DIV_W(DIV_W), .NUM_DLY(NUM_DLY)) u_rates (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(start_ok),
    .div_i (rate_div_i),
    .div_o (div_held)
  );

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_stage
    assign run[g] = act_q[g] && !act_q[g+1] && !fault_i;

    pgs_delay_stage #(.DIV_W(DIV_W), .PERIODS(PERIODS)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run[g]),
      .div_i (div_held[g*DIV_W +: DIV_W]),
      .done_o(done[g])
    );

    // R9
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[g+1] |-> act_q[g]);
  end

  // Flag state: set in sequence, cleared all at once by a fault.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (fault_i) begin
      act_q <= '0;
    end else begin
      if (start_ok) act_q[0] <= 1'b1;
      for (int i = 0; i < NUM_DLY; i++) begin
        if (done[i]) act_q[i+1] <= 1'b1;
      end
    end
  end

  // Low-power request follows the final flag by one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
    end else if (fault_i) begin
      sleep_q <= 1'b0;
    end else if (act_q[LASTF]) begin
      sleep_q <= 1'b1;
    end
  end

  pgs_pol_out #(.NUM_FLAGS(NUM_FLAGS)) u_pins (
    .active_i(act_q),
    .pol_hi_i(pol_hi_i),
    .flag_o  (flag_o)
  );

  assign sleep_req_o = sleep_q;

  // R5
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (act_q == '0 && !sleep_q));

  // R2
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q[0]) |-> $past(start_i));

  // R7
  sleep_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> act_q[LASTF]);

  // R7
  sleep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> $past(act_q[LASTF]));
endmodule

// File: tb/sim_pgood_sequencer.sv
module sim_pgood_sequencer;
  localparam int DIV_W = 8;
  localparam int NF    = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            fault_i = 1'b0;
  logic            pol_hi_i = 1'b1;
  logic [3*DIV_W-1:0] rate_div_i = '0;
  logic [NF-1:0]   flag_o;
  logic            sleep_req_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pgood_sequencer #(.NUM_FLAGS(NF), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_i),
    .pol_hi_i(pol_hi_i), .rate_div_i(rate_div_i),
    .flag_o(flag_o), .sleep_req_o(sleep_req_o)
  );

  function automatic logic [NF-1:0] pattern(input int n_act, input logic pol);
    logic [NF-1:0] p;
    for (int i = 0; i < NF; i++) p[i] = (i < n_act) ? pol : ~pol;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Counts falling edges until flag idx is active; inj>0 pulses start at that count.
  task automatic time_flag(input int idx, input int exp, input int inj, input string req);
    int k = 0;
    while (flag_o[idx] !== pol_hi_i && k < 5000) begin
      @(negedge clk);
      k++;
      start_i = (k == inj);
    end
    start_i = 1'b0;
    check(k == exp, req, k, exp);
    check(flag_o == pattern(idx + 1, pol_hi_i), "R9", flag_o, pattern(idx + 1, pol_hi_i));
  endtask

  task automatic run_case(input int db, input int dc, input int dd, input logic pol, input int inj);
    pol_hi_i   = pol;
    rate_div_i = {8'(dd), 8'(dc), 8'(db)};
    pulse_start();
    // R4: later divider changes must not alter the running delays
    rate_div_i = {8'(dd + 3), 8'(dc + 5), 8'(db + 7)};
    check(flag_o == pattern(1, pol), "R2", flag_o, pattern(1, pol));
    check(sleep_req_o == 1'b0, "R7", sleep_req_o, 0);
    time_flag(1, 255 * (db + 1), inj, "R3/R4 B delay");
    time_flag(2, 255 * (dc + 1), 0, "R3/R4 C delay");
    check(sleep_req_o == 1'b0, "R7", sleep_req_o, 0);
    time_flag(3, 255 * (dd + 1), 0, "R3/R4 D delay");
    check(sleep_req_o == 1'b0, "R7 same cycle as D", sleep_req_o, 0);
    @(negedge clk);
    check(sleep_req_o == 1'b1, "R7 one cycle after D", sleep_req_o, 1);
    repeat (10) @(negedge clk);
    check(sleep_req_o == 1'b1 && flag_o == pattern(4, pol), "R7 hold", sleep_req_o, 1);
    fault_i = 1'b1;
    @(negedge clk);
    fault_i = 1'b0;
    check(flag_o == pattern(0, pol), "R5 clear", flag_o, pattern(0, pol));
    check(sleep_req_o == 1'b0, "R5 sleep clear", sleep_req_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flag_o == 4'b0000 && sleep_req_o == 1'b0, "R1 in reset", flag_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(flag_o == 4'b0000 && sleep_req_o == 1'b0, "R1 idle", flag_o, 0);
    pol_hi_i = 1'b0;
    #1;
    check(flag_o == 4'b1111, "R8 active-low idle", flag_o, 4'b1111);
    pol_hi_i = 1'b1;
    @(negedge clk);

    run_case(0, 0, 0, 1'b1, 0);
    run_case(1, 2, 3, 1'b1, 100);   // R2: start during B delay ignored
    run_case(3, 0, 1, 1'b0, 0);
    run_case(2, 1, 0, 1'b0, 300);

    // R8: live strap flip mid-sequence
    pol_hi_i   = 1'b1;
    rate_div_i = '0;
    pulse_start();
    pol_hi_i = 1'b0;
    #1;
    check(flag_o == 4'b1110, "R8 live flip", flag_o, 4'b1110);
    pol_hi_i = 1'b1;
    #1;
    check(flag_o == 4'b0001, "R8 live flip back", flag_o, 4'b0001);

    // R5: fault and start together mid-delay
    repeat (100) @(negedge clk);
    fault_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    fault_i = 1'b0;
    start_i = 1'b0;
    check(flag_o == 4'b0000, "R5 fault beats start", flag_o, 0);
    repeat (3) @(negedge clk);
    check(flag_o == 4'b0000, "R5 stays clear", flag_o, 0);

    // R6: restart counts a full delay again
    run_case(0, 0, 0, 1'b1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule